// File: doc/BRIEF.md
# Debug Mode Memory Overlay Controller

This block keeps two state bits for a processor's debug facility: whether debug is enabled and whether it is currently active. It uses them to steer every access in a 16-bit address space to one of three targets: user memory, a small debug ROM, or a bank of debug control registers. A two-bit operating-mode strap decides how the block starts after reset. One mode brings debug up already enabled and active, and suppresses the reset vector fetch. Another mode must never let debug become active, because an external master owns the internal bus in that mode.

While debug is active, the top 256-byte window (0xFF00 to 0xFFFF) is overlaid for CPU accesses. The lowest seven locations of the window go to the debug registers and the rest go to the debug ROM, including the system vectors. Accesses tagged as coming from a serial debug command still reach user memory behind the overlay. Software sets or clears the enable bit with a write strobe. A decoded serial "enter" command or a CPU background strobe activates debug, and a CPU "exit" strobe leaves it.

Top module: `dbg_overlay_ctrl`

## Requirements
- R1: With mode strap 2'b10 (special single-chip), `dbg_en_o` and `dbg_act_o` are 1 from the first cycle after reset release, and `rst_vec_fetch_o` stays 0.
- R2: With any other strap (2'b00, 2'b01 or 2'b11), `dbg_en_o` and `dbg_act_o` are 0 after reset, and `rst_vec_fetch_o` is 1 for exactly the first cycle after reset release.
- R3: A cycle with `en_wr_i`=1 loads `en_data_i` into the enable bit, which `dbg_en_o` shows from the next cycle. A write does not change the active state.
- R4: While `dbg_en_o`=1, a cycle with `ser_enter_i`=1 or `cpu_bgnd_i`=1 makes `dbg_act_o` 1 from the next cycle.
- R5: Activation requests in a cycle with `dbg_en_o`=0 are ignored. They are not remembered, so `dbg_act_o` stays 0 even after debug is enabled later.
- R6: `cpu_exit_i`=1 makes `dbg_act_o` 0 from the next cycle and leaves `dbg_en_o` unchanged. When exit and an activation request fall in the same cycle, exit wins.
- R7: With mode strap 2'b11 (special peripheral), `dbg_act_o` never becomes 1, even when debug is enabled and requested.
- R8: While `dbg_act_o`=0, every valid access, including any in 0xFF00 to 0xFFFF, selects user memory (`cs_user_o`).
- R9: While `dbg_act_o`=1, a valid CPU access (`acc_ser_i`=0) in 0xFF07 to 0xFFFF selects the debug ROM (`cs_rom_o`), including the vector locations.
- R10: While `dbg_act_o`=1, a valid CPU access in 0xFF00 to 0xFF06 selects the debug registers (`cs_reg_o`), which take priority over the ROM.
- R11: A valid access with `acc_ser_i`=1 always selects user memory, whatever the state and the address.
- R12: Exactly one chip select is 1 in a cycle with `acc_valid_i`=1, and none is 1 when `acc_valid_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating-mode strap: 00 normal single-chip, 01 normal expanded, 10 special single-chip, 11 special peripheral |
| en_wr_i | input | 1 | Software write strobe for the enable bit |
| en_data_i | input | 1 | Value written to the enable bit |
| ser_enter_i | input | 1 | Decoded serial "enter background" command |
| cpu_bgnd_i | input | 1 | CPU background-instruction strobe |
| cpu_exit_i | input | 1 | CPU "exit background" strobe |
| acc_valid_i | input | 1 | Access cycle valid |
| acc_addr_i | input | 16 | Access address |
| acc_ser_i | input | 1 | Access comes from a serial debug command |
| cs_user_o | output | 1 | User memory select |
| cs_rom_o | output | 1 | Debug ROM select |
| cs_reg_o | output | 1 | Debug register select |
| dbg_en_o | output | 1 | Debug enabled |
| dbg_act_o | output | 1 | Debug active |
| rst_vec_fetch_o | output | 1 | Reset vector fetch permitted (first cycle after reset) |

## Verification
The chip selects are combinational, so they reflect the access and the state in the same cycle. Any strobe or enable write shows on `dbg_en_o` and `dbg_act_o` one clock edge later. The boot flags (`rst_vec_fetch_o` and the special single-chip start-up state) are visible in the first cycle after reset release. The bench drives each cycle's inputs at the falling edge and pushes the outputs it expects for that same cycle. It then updates its own model of the two state bits as of the next rising edge. The monitor samples a quarter period after the falling edge, so a request is always checked in the cycle after it was issued.

// File: rtl/dbg_overlay_pkg.sv
package dbg_overlay_pkg;
  typedef enum logic [1:0] {
    MODE_NORM_SC  = 2'b00,
    MODE_NORM_EXP = 2'b01,
    MODE_SPEC_SC  = 2'b10,
    MODE_SPEC_PER = 2'b11
  } op_mode_e;

  typedef struct packed {
    logic user;
    logic rom;
    logic regs;
  } cs_t;
endpackage

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
  import dbg_overlay_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  op_mode_e mode_i,
  input  logic     en_wr_i,
  input  logic     en_data_i,
  input  logic     ser_enter_i,
  input  logic     cpu_bgnd_i,
  input  logic     cpu_exit_i,
  output logic     en_o,
  output logic     act_o,
  output logic     boot_o
);
  logic boot_q, en_q, act_q;
  logic spec_sc, spec_per, en_eff, act_eff, en_d, act_d;

  assign spec_sc  = (mode_i == MODE_SPEC_SC);
  assign spec_per = (mode_i == MODE_SPEC_PER);

  // boot cycle: special single-chip comes up enabled and active
  assign en_eff  = en_q  | (boot_q & spec_sc);
  assign act_eff = act_q | (boot_q & spec_sc);

  always_comb begin
    en_d  = en_wr_i ? en_data_i : en_eff;
    act_d = act_eff;
    if (cpu_exit_i)
      act_d = 1'b0;
    else if (en_eff && (ser_enter_i || cpu_bgnd_i))
      act_d = 1'b1;
    if (spec_per)
      act_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q <= 1'b1;
      en_q   <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      en_q   <= en_d;
      act_q  <= act_d;
    end
  end

  assign en_o   = en_eff;
  assign act_o  = act_eff;
  assign boot_o = boot_q;
endmodule

// File: rtl/dbg_win_decode.sv
module dbg_win_decode
  import dbg_overlay_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WIN_LSB = 8,
  parameter int REG_CNT = 7
) (
  input  logic              act_i,
  input  logic              valid_i,
  input  logic              ser_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cs_t               cs_o
);
  localparam logic [WIN_LSB-1:0] REG_LIM = WIN_LSB'(REG_CNT);

  logic in_win, in_regs, overlay;

  assign in_win  = &addr_i[ADDR_W-1:WIN_LSB];
  assign in_regs = addr_i[WIN_LSB-1:0] < REG_LIM;
  assign overlay = act_i & in_win & ~ser_i;

  always_comb begin
    cs_o = '0;
    if (valid_i) begin
      if (!overlay)     cs_o.user = 1'b1;
      else if (in_regs) cs_o.regs = 1'b1;
      else              cs_o.rom  = 1'b1;
    end
  end
endmodule

// File: rtl/dbg_overlay_ctrl.sv
module dbg_overlay_ctrl
  import dbg_overlay_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WIN_LSB = 8,
  parameter int REG_CNT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              en_wr_i,
  input  logic              en_data_i,
  input  logic              ser_enter_i,
  input  logic              cpu_bgnd_i,
  input  logic              cpu_exit_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_ser_i,
  output logic              cs_user_o,
  output logic              cs_rom_o,
  output logic              cs_reg_o,
  output logic              dbg_en_o,
  output logic              dbg_act_o,
  output logic              rst_vec_fetch_o
);
  op_mode_e mode;
  logic     en, act, boot;
  cs_t      cs;

  assign mode = op_mode_e'(mode_i);

  dbg_mode_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .en_wr_i     (en_wr_i),
    .en_data_i   (en_data_i),
    .ser_enter_i (ser_enter_i),
    .cpu_bgnd_i  (cpu_bgnd_i),
    .cpu_exit_i  (cpu_exit_i),
    .en_o        (en),
    .act_o       (act),
    .boot_o      (boot)
  );

  dbg_win_decode #(
    .ADDR_W  (ADDR_W),
    .WIN_LSB (WIN_LSB),
    .REG_CNT (REG_CNT)
  ) i_dec (
    .act_i   (act),
    .valid_i (acc_valid_i),
    .ser_i   (acc_ser_i),
    .addr_i  (acc_addr_i),
    .cs_o    (cs)
  );

  assign cs_user_o       = cs.user;
  assign cs_rom_o        = cs.rom;
  assign cs_reg_o        = cs.regs;
  assign dbg_en_o        = en;
  assign dbg_act_o       = act;
  assign rst_vec_fetch_o = boot & (mode != MODE_SPEC_SC);
endmodule

// File: rtl/dbg_overlay_chk.sv
module dbg_overlay_chk #(
  parameter int ADDR_W  = 16,
  parameter int WIN_LSB = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              en_wr_i,
  input logic              ser_enter_i,
  input logic              cpu_bgnd_i,
  input logic              cpu_exit_i,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              acc_ser_i,
  input logic              cs_user_o,
  input logic              cs_rom_o,
  input logic              cs_reg_o,
  input logic              dbg_en_o,
  input logic              dbg_act_o
);
  logic in_win;
  assign in_win = &acc_addr_i[ADDR_W-1:WIN_LSB];

  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |-> $countones({cs_user_o, cs_rom_o, cs_reg_o}) == 1); // R12
  AST_CS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> !(cs_user_o || cs_rom_o || cs_reg_o)); // R12
  AST_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_en_o && (ser_enter_i || cpu_bgnd_i) && !cpu_exit_i && mode_i != 2'b11)
      |=> dbg_act_o); // R4
  AST_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_en_o && !dbg_act_o) |=> !dbg_act_o); // R5
  AST_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_exit_i |=> !dbg_act_o); // R6
  AST_EXIT_KEEP_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_exit_i && !en_wr_i && dbg_en_o) |=> dbg_en_o); // R6
  AST_PERIPH_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |-> !dbg_act_o); // R7
  AST_HIDE_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_act_o && acc_valid_i && !acc_ser_i && in_win) |-> !cs_user_o); // R9
  AST_SER_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_ser_i) |-> cs_user_o); // R11
  AST_INACT_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_act_o && acc_valid_i) |-> cs_user_o); // R8
endmodule

bind dbg_overlay_ctrl dbg_overlay_chk #(
  .ADDR_W  (ADDR_W),
  .WIN_LSB (WIN_LSB)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .en_wr_i     (en_wr_i),
  .ser_enter_i (ser_enter_i),
  .cpu_bgnd_i  (cpu_bgnd_i),
  .cpu_exit_i  (cpu_exit_i),
  .acc_valid_i (acc_valid_i),
  .acc_addr_i  (acc_addr_i),
  .acc_ser_i   (acc_ser_i),
  .cs_user_o   (cs_user_o),
  .cs_rom_o    (cs_rom_o),
  .cs_reg_o    (cs_reg_o),
  .dbg_en_o    (dbg_en_o),
  .dbg_act_o   (dbg_act_o)
);

// File: tb/test_dbg_overlay_ctrl.sv
module test_dbg_overlay_ctrl;
  logic clk_i = 1'b0;
  always #10 clk_i = ~clk_i;  // 50 MHz

  logic        rst_ni, en_wr_i, en_data_i, ser_enter_i, cpu_bgnd_i, cpu_exit_i;
  logic        acc_valid_i, acc_ser_i;
  logic [1:0]  mode_i;
  logic [15:0] acc_addr_i;
  logic        cs_user_o, cs_rom_o, cs_reg_o, dbg_en_o, dbg_act_o, rst_vec_fetch_o;

  dbg_overlay_ctrl i_dbg_overlay_ctrl (
    .clk_i, .rst_ni, .mode_i, .en_wr_i, .en_data_i, .ser_enter_i, .cpu_bgnd_i,
    .cpu_exit_i, .acc_valid_i, .acc_addr_i, .acc_ser_i, .cs_user_o, .cs_rom_o,
    .cs_reg_o, .dbg_en_o, .dbg_act_o, .rst_vec_fetch_o
  );

  typedef struct {
    logic [2:0] cs;   // {user, rom, regs}
    logic       en;
    logic       act;
    logic       vec;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;
  bit   m_boot, m_en, m_act;

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got cs/en/act/vec=%b expected %b", tag, got, exp);
    end
  endtask

  // driver: apply one cycle, push expected outputs, advance the model
  task automatic step(input logic wr, input logic wd, input logic se, input logic bg,
                      input logic ex, input logic v, input logic sr,
                      input logic [15:0] a, input string tag);
    exp_t e;
    logic ssc, per, en_eff, act_eff, win, regs;
    en_wr_i = wr; en_data_i = wd; ser_enter_i = se; cpu_bgnd_i = bg;
    cpu_exit_i = ex; acc_valid_i = v; acc_ser_i = sr; acc_addr_i = a;
    ssc = (mode_i == 2'b10);
    per = (mode_i == 2'b11);
    en_eff  = m_en  | (m_boot & ssc);
    act_eff = m_act | (m_boot & ssc);
    win  = (a[15:8] == 8'hFF);
    regs = (a[7:0] <= 8'h06);
    if (!v)                          e.cs = 3'b000;
    else if (!act_eff || sr || !win) e.cs = 3'b100;
    else if (regs)                   e.cs = 3'b001;
    else                             e.cs = 3'b010;
    e.en = en_eff; e.act = act_eff; e.vec = m_boot & !ssc; e.tag = tag;
    q.push_back(e);
    m_boot = 1'b0;
    m_en   = wr ? wd : en_eff;
    if (ex)                    m_act = 1'b0;
    else if (en_eff && (se || bg)) m_act = 1'b1;
    else                       m_act = act_eff;
    if (per) m_act = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 16'h0000, tag);
  endtask

  task automatic cpu(input logic [15:0] a, input string tag);
    step(0, 0, 0, 0, 0, 1, 0, a, tag);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk_i);
    rst_ni = 1'b0; mode_i = m;
    en_wr_i = 0; en_data_i = 0; ser_enter_i = 0; cpu_bgnd_i = 0; cpu_exit_i = 0;
    acc_valid_i = 0; acc_ser_i = 0; acc_addr_i = '0;
    m_boot = 1'b1; m_en = 1'b0; m_act = 1'b0;
    @(negedge clk_i);
    #5;
    if (m != 2'b10)
      check("R2 reset state", {cs_user_o, cs_rom_o, cs_reg_o, dbg_en_o, dbg_act_o, 1'b0},
            6'b000000);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, {cs_user_o, cs_rom_o, cs_reg_o, dbg_en_o, dbg_act_o, rst_vec_fetch_o},
              {e.cs, e.en, e.act, e.vec});
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; mode_i = 2'b00;
    // normal single-chip
    do_reset(2'b00);
    idle("R2 vector fetch first cycle");
    idle("R2 vector fetch cleared");
    step(0, 0, 1, 0, 0, 0, 0, 16'h0, "R5 serial enter while disabled");
    step(0, 0, 0, 1, 0, 0, 0, 16'h0, "R5 bgnd while disabled");
    cpu(16'hFF00, "R8 inactive FF00 user");
    cpu(16'hFFFE, "R8 inactive vector user");
    step(1, 1, 0, 0, 0, 0, 0, 16'h0, "R3 enable write");
    idle("R5 no latched request after enable");
    step(0, 0, 1, 0, 0, 0, 0, 16'h0, "R4 serial enter");
    cpu(16'hFF00, "R10 reg low edge");
    cpu(16'hFF06, "R10 reg high edge");
    cpu(16'hFF07, "R9 rom first");
    cpu(16'hFFFE, "R9 rom vector");
    cpu(16'h1234, "R8 outside window user");
    step(0, 0, 0, 0, 0, 1, 1, 16'hFF03, "R11 serial access reg area");
    step(0, 0, 0, 0, 0, 1, 1, 16'hFFFF, "R11 serial access rom area");
    step(0, 0, 0, 0, 0, 0, 0, 16'hFF03, "R12 invalid no select");
    step(0, 0, 1, 1, 1, 0, 0, 16'h0, "R6 exit beats enter");
    idle("R6 enable kept");
    step(0, 0, 0, 1, 0, 0, 0, 16'h0, "R4 bgnd strobe");
    step(1, 0, 0, 0, 0, 1, 0, 16'hFF10, "R3 disable does not clear active");
    step(0, 0, 0, 0, 1, 0, 0, 16'h0, "R6 exit");
    step(0, 0, 0, 1, 0, 0, 0, 16'h0, "R5 bgnd while disabled again");
    idle("R5 still inactive");
    // special single-chip
    do_reset(2'b10);
    cpu(16'hFFFE, "R1 active out of reset");
    cpu(16'hFF02, "R1 regs out of reset");
    step(0, 0, 0, 0, 1, 0, 0, 16'h0, "R6 exit in special mode");
    cpu(16'hFFFE, "R6 enabled inactive");
    // special peripheral
    do_reset(2'b11);
    idle("R2 peripheral reset");
    step(1, 1, 0, 0, 0, 0, 0, 16'h0, "R3 enable in peripheral mode");
    step(0, 0, 1, 1, 0, 0, 0, 16'h0, "R7 request blocked");
    cpu(16'hFF00, "R7 still inactive");
    // normal expanded
    do_reset(2'b01);
    idle("R2 expanded reset");
    cpu(16'hFFF0, "R8 expanded inactive");
    idle("R12 drain");
    @(negedge clk_i);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule